// File: doc/BRIEF.md
# DMA Controller Register Block and Interrupt Latches

This block is the software-visible face of a multi-channel DMA controller, built for either eight or two channels. A word-addressed bus with separate read and write strobes reaches two register groups. One group is global: interrupt status in masked and raw forms, per-source clear words, a bitmap of enabled channels and a small controller configuration word. The other group holds five 32-bit words for each channel: source address, destination address, link pointer, control and configuration.

The transfer engine reports a channel's terminal count or error with a one-cycle pulse. The block keeps one sticky latch bit per channel for each kind of event. The masks for these latches come from bits of each channel's own configuration word. A single level interrupt is raised while any latch bit is set whose mask bit is also set. The enabled-channel bitmap is not stored separately. It is built at read time from bit 0 of every channel's configuration word. A fixed block of identification bytes near the top of the address space can be read, and its first byte depends on the channel count.

Top module: `dma_regfile`

## Requirements
- R1: After reset every channel word, both latches and the controller configuration are zero, and `irq` is low.
- R2: A write to byte offset 0x100 + 0x20*c + 4*w, with channel c below the channel count and w from 0 to 4 (source, destination, link, control, configuration), stores all 32 data bits. A read of the same offset returns them.
- R3: A channel-region offset with channel index c (offset bits 7:5) at or above the channel count, or with w from 5 to 7, reads as zero and ignores writes.
- R4: A one-cycle pulse on bit c of `tc_set` or `err_set` sets the matching latch bit. Raw terminal-count status reads at offset 0x14 and raw error status at 0x18, channel c in bit c, whatever the masks hold.
- R5: Masked terminal-count status at 0x04 is the raw terminal-count status ANDed with each channel's configuration bit 15. Masked error status at 0x0C is the raw error status ANDed with configuration bit 14. Offset 0x00 is the OR of the two.
- R6: Writing offset 0x08 clears each terminal-count latch bit whose data bit is 1. Offset 0x10 does the same for the error latch.
- R7: When a set pulse and a clear write reach the same latch bit in the same cycle, the bit ends up set.
- R8: Offset 0x1C reads a bitmap whose bit c is bit 0 of channel c's configuration word.
- R9: Offset 0x30 stores data bits 2:0 (bit 0 global enable, bits 2:1 endianness select) and reads back only those bits.
- R10: `irq` is high exactly when the masked combined status is non-zero.
- R11: Offsets 0xFE0 to 0xFFC each read one identification byte in bits 7:0: 0x80 (eight channels) or 0x81 (other counts), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. Writes there have no effect.
- R12: Any other offset reads as zero and ignores writes, and `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Word address (byte offset divided by 4) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational, valid while rd_en is high |
| tc_set | input | NCH | Terminal-count event pulses, one per channel |
| err_set | input | NCH | Error event pulses, one per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a set pulse and a software clear that hit the same latch bit in the same cycle. The bench makes it by raising `tc_set` and the clear-word write strobe together inside a single clock period. Decoding is checked by writing a distinct pattern to every word of the channel region, then reading back the whole 4 KB space and comparing each word against a bench model. Because the model is built from the requirements, aliasing into unused channel indices, into unused words or into the global region would show up as a mismatch. The same full sweep runs after reset, after the interrupt sequence and after writes to unmapped offsets.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [9:0]     addr,
  input  logic           wr_en,
  input  logic [31:0]    wdata,
  input  logic           rd_en,
  output logic [31:0]    rdata,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  output logic           irq
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [7:0] ID_FIRST = (NCH == 8) ? 8'h80 : 8'h81;

  logic [NCH-1:0][31:0] src_q, dst_q, lli_q, ctl_q, cfg_q;
  logic [NCH-1:0] tc_q, err_q, tc_msk, err_msk, chan_on;
  logic [2:0] gcfg_q;
  logic [31:0] rd_mux;

  wire       chan_sel = addr[9:6] == 4'h1;
  wire [2:0] cidx     = addr[5:3];
  wire [2:0] cword    = addr[2:0];
  wire       chan_ok  = chan_sel && (32'(cidx) < NCH) && (cword <= 3'd4);
  wire [IW-1:0] ci    = cidx[IW-1:0];
  wire       glob_sel = addr[9:6] == 4'h0;
  wire [5:0] gword    = addr[5:0];
  wire       id_sel   = addr[9:3] == 7'h7F;

  wire clr_tc  = wr_en && glob_sel && gword == 6'd2;
  wire clr_err = wr_en && glob_sel && gword == 6'd4;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign tc_msk[c]  = cfg_q[c][15];
    assign err_msk[c] = cfg_q[c][14];
    assign chan_on[c] = cfg_q[c][0];
  end

  wire [NCH-1:0] tc_vis  = tc_q & tc_msk;
  wire [NCH-1:0] err_vis = err_q & err_msk;
  assign irq = |{tc_vis, err_vis};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      lli_q  <= '0;
      ctl_q  <= '0;
      cfg_q  <= '0;
      tc_q   <= '0;
      err_q  <= '0;
      gcfg_q <= '0;
    end else begin
      if (wr_en && chan_ok) begin
        case (cword)
          3'd0: src_q[ci] <= wdata;
          3'd1: dst_q[ci] <= wdata;
          3'd2: lli_q[ci] <= wdata;
          3'd3: ctl_q[ci] <= wdata;
          default: cfg_q[ci] <= wdata;
        endcase
      end
      if (wr_en && glob_sel && gword == 6'd12) gcfg_q <= wdata[2:0];
      tc_q  <= (tc_q  & ~(clr_tc  ? wdata[NCH-1:0] : '0)) | tc_set;
      err_q <= (err_q & ~(clr_err ? wdata[NCH-1:0] : '0)) | err_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (chan_ok) begin
      case (cword)
        3'd0: rd_mux = src_q[ci];
        3'd1: rd_mux = dst_q[ci];
        3'd2: rd_mux = lli_q[ci];
        3'd3: rd_mux = ctl_q[ci];
        default: rd_mux = cfg_q[ci];
      endcase
    end else if (glob_sel) begin
      case (gword)
        6'd0:  rd_mux = 32'(tc_vis | err_vis);
        6'd1:  rd_mux = 32'(tc_vis);
        6'd3:  rd_mux = 32'(err_vis);
        6'd5:  rd_mux = 32'(tc_q);
        6'd6:  rd_mux = 32'(err_q);
        6'd7:  rd_mux = 32'(chan_on);
        6'd12: rd_mux = 32'(gcfg_q);
        default: rd_mux = '0;
      endcase
    end else if (id_sel) begin
      case (addr[2:0])
        3'd0: rd_mux = 32'(ID_FIRST);
        3'd1: rd_mux = 32'h10;
        3'd2: rd_mux = 32'h04;
        3'd3: rd_mux = 32'h0A;
        3'd4: rd_mux = 32'h0D;
        3'd5: rd_mux = 32'hF0;
        3'd6: rd_mux = 32'h05;
        default: rd_mux = 32'hB1;
      endcase
    end
  end

  assign rdata = rd_en ? rd_mux : '0;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));

  assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((err_q & $past(err_set)) == $past(err_set)));

  assert_tc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && glob_sel && gword == 6'd2 && tc_set == '0)
      |=> ((tc_q & $past(wdata[NCH-1:0])) == '0));

  assert_bad_chan_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chan_sel && !chan_ok)
      |=> ($stable(src_q) && $stable(dst_q) && $stable(lli_q) && $stable(ctl_q) && $stable(cfg_q)));

  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && glob_sel && gword != 6'd2 && gword != 6'd4 && gword != 6'd12
      && tc_set == '0 && err_set == '0)
      |=> ($stable(tc_q) && $stable(err_q) && $stable(gcfg_q)));

  assert_read_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic clk = 0, rst_n = 0;
  logic [9:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] tc_set = '0, err_set = '0;
  logic irq;

  int total = 0, bad = 0;

  logic [31:0] m_ch [N][5];
  logic [N-1:0] m_tc, m_er;
  logic [2:0] m_g;

  dma_regfile #(.NCH(N)) i_dma_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .tc_set(tc_set), .err_set(err_set), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] tcm();
    for (int c = 0; c < N; c++) tcm[c] = m_ch[c][4][15];
  endfunction
  function automatic logic [N-1:0] erm();
    for (int c = 0; c < N; c++) erm[c] = m_ch[c][4][14];
  endfunction
  function automatic logic [N-1:0] enm();
    for (int c = 0; c < N; c++) enm[c] = m_ch[c][4][0];
  endfunction

  function automatic logic [31:0] model_rd(int a);
    logic [7:0] idb [8] = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 'h100 && a < 'h200) begin
      int c = (a >> 5) & 7, w = (a >> 2) & 7;
      return (c < N && w <= 4) ? m_ch[c][w] : 32'h0;
    end
    if (a < 'h100) begin
      case (a >> 2)
        0: return 32'((m_tc & tcm()) | (m_er & erm()));
        1: return 32'(m_tc & tcm());
        3: return 32'(m_er & erm());
        5: return 32'(m_tc);
        6: return 32'(m_er);
        7: return 32'(enm());
        12: return 32'(m_g);
        default: return 32'h0;
      endcase
    end
    if (a >= 'hFE0) return 32'(idb[(a - 'hFE0) >> 2]);
    return 32'h0;
  endfunction

  function automatic string tag_of(int a);
    if (a >= 'h100 && a < 'h200)
      return ((((a >> 5) & 7) < N) && (((a >> 2) & 7) <= 4)) ? "R2" : "R3";
    if (a >= 'hFE0) return "R11";
    if (a < 'h100) begin
      case (a >> 2)
        0, 1, 3: return "R5";
        5, 6: return "R4";
        7: return "R8";
        12: return "R9";
        default: return "R12";
      endcase
    end
    return "R12";
  endfunction

  function automatic void model_wr(int a, logic [31:0] d);
    if (a >= 'h100 && a < 'h200) begin
      int c = (a >> 5) & 7, w = (a >> 2) & 7;
      if (c < N && w <= 4) m_ch[c][w] = d;
    end else if (a == 'h08) m_tc = m_tc & ~d[N-1:0];
    else if (a == 'h10) m_er = m_er & ~d[N-1:0];
    else if (a == 'h30) m_g = d[2:0];
  endfunction

  task automatic cyc(int a, logic w, logic [31:0] d, logic [N-1:0] ts, logic [N-1:0] es);
    @(negedge clk);
    addr = 10'(a >> 2); wdata = d; wr_en = w; tc_set = ts; err_set = es;
    @(negedge clk);
    wr_en = 0; tc_set = '0; err_set = '0;
    if (w) model_wr(a, d);
    m_tc = m_tc | ts;
    m_er = m_er | es;
  endtask

  task automatic wr(int a, logic [31:0] d);
    cyc(a, 1'b1, d, '0, '0);
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    addr = 10'(a >> 2); rd_en = 1;
    #1 chk(req, rdata, model_rd(a));
    rd_en = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 'h1000; a += 4) rd(a, tag_of(a));
    #1 chk("R10", 32'(irq), 32'(|((m_tc & tcm()) | (m_er & erm()))));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) for (int w = 0; w < 5; w++) m_ch[c][w] = '0;
    m_tc = '0; m_er = '0; m_g = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: everything zero after reset
    #1 chk("R1", 32'(irq), 32'h0);
    chk("R12", rdata, 32'h0);
    sweep();

    // R2 / R3: distinct pattern into every channel-region word
    for (int a = 'h100; a < 'h200; a += 4)
      wr(a, 32'hA5000000 ^ (32'(a) * 32'h00010101));
    // clear config bits 15/14/0 set by the pattern to known values
    for (int c = 0; c < N; c++) wr('h110 + 'h20 * c, 32'h0);
    sweep();

    // R4 / R5 / R10: ch0 masks on, ch1 masks off
    wr('h110, 32'h0000C001);
    cyc(0, 1'b0, 0, 2'b11, 2'b00);
    rd('h14, "R4"); rd('h04, "R5"); rd('h00, "R5");
    #1 chk("R10", 32'(irq), 32'h1);
    // R6: clear ch0 terminal count
    wr('h08, 32'h1);
    rd('h14, "R6");
    #1 chk("R10", 32'(irq), 32'h0);
    cyc(0, 1'b0, 0, 2'b00, 2'b10);
    rd('h18, "R4"); rd('h0C, "R5");
    #1 chk("R10", 32'(irq), 32'h0);
    wr('h130, 32'h00004000);
    rd('h0C, "R5"); rd('h00, "R5"); rd('h1C, "R8");
    #1 chk("R10", 32'(irq), 32'h1);
    wr('h10, 32'hFFFFFFFF);
    rd('h18, "R6");
    #1 chk("R10", 32'(irq), 32'h0);

    // R7: set and clear of the same bit in one cycle
    cyc('h08, 1'b1, 32'h3, 2'b01, 2'b00);
    rd('h14, "R7");
    chk("R7", 32'(m_tc), 32'h1);
    #1 chk("R10", 32'(irq), 32'h1);

    // R9: controller configuration keeps three bits
    wr('h30, 32'hFFFFFFFF);
    rd('h30, "R9");
    wr('h30, 32'h00000005);
    rd('h30, "R9");

    // R12 / R11: writes to unmapped and identification offsets
    wr('h20, 32'hFFFFFFFF); wr('h2C, 32'hFFFFFFFF); wr('h14, 32'hFFFFFFFF);
    wr('h200, 32'hFFFFFFFF); wr('hFE0, 32'hFFFFFFFF); wr('h1F0, 32'hFFFFFFFF);
    sweep();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule